// File: doc/BRIEF.md
# Addressed Serial Volume Control Register

This block takes stereo volume commands from a host over a three-wire serial link: a data line, a shift clock and a latch strobe. All three lines are brought into a faster system clock domain through synchronisers, and their edges are detected there. Each rising edge of the shift clock moves one data bit into a 16-bit shift register. A rising edge of the latch strobe then commits the last 16 bits that were shifted in.

A committed word carries a 2-bit device address, a 2-bit channel selector and an 8-bit attenuation code. The device address is compared with two strap inputs, which lets four of these blocks share one serial bus. When the address matches, the code is stored in the left register, the right register or both. Each register is decoded into an attenuation step in dB and a mute flag. Each write also raises a one-cycle update strobe, which tells the downstream attenuator to load the new setting.

Top module: `serial_volume_ctrl`

## Requirements
- R1: Serial data is shifted in on each rising edge of the shift clock, most significant bit first, so the first of the final 16 bits becomes word bit 15.
- R2: A rising edge of the latch strobe commits the last 16 bits shifted in; earlier bits in a longer burst have no effect.
- R3: A latch edge that follows fewer than 16 shift-clock pulses is ignored. Every latch edge, accepted or not, restarts the pulse count from zero. The count saturates at 31.
- R4: A command is applied only when word bit 13 equals strap_a1_i and word bit 12 equals strap_a0_i. Any other command changes no register and raises no strobe.
- R5: Word bits 9:8 select the target: 00 writes both channels, 01 writes left only, 10 writes right only, 11 writes neither.
- R6: An attenuation code (word bits 7:0) from 0 to 80 gives a step output equal to the code and a low mute flag.
- R7: Any code from 81 to 255 gives a high mute flag with the step output held at 80.
- R8: A low rst_ni puts both channels in mute with step 80 and no strobe. They stay that way until an addressed command writes them.
- R9: Each written channel raises its update strobe for exactly one system clock cycle, even when the new code equals the old one.
- R10: Word bits 15:14 and 11:10 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous, idles high when undriven |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_lat_i | input | 1 | Serial latch strobe, asynchronous |
| strap_a1_i | input | 1 | Address strap compared with word bit 13 (static) |
| strap_a0_i | input | 1 | Address strap compared with word bit 12 (static) |
| left_step_o | output | 7 | Left attenuation in dB, 0 to 80 |
| left_mute_o | output | 1 | Left mute flag |
| left_upd_o | output | 1 | Left one-cycle update strobe |
| right_step_o | output | 7 | Right attenuation in dB, 0 to 80 |
| right_mute_o | output | 1 | Right mute flag |
| right_upd_o | output | 1 | Right one-cycle update strobe |

## Verification
The bench instantiates the block with its default parameters: a 16-bit word, an 8-bit code, a 7-bit step limited to 80, and two synchroniser stages.

With these values the bench can reach the following cases:
- the 80/81 boundary between the last attenuation step and mute;
- the 15-pulse short burst that must be rejected;
- a 40-pulse burst that drives the pulse counter into saturation while only its final 16 bits are committed.

The straps are tied to a mixed pattern (1, 0), so a swapped address bit compare is caught.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [1:0] {
    SEL_BOTH  = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_HOLD  = 2'b11
  } chan_sel_e;

  localparam int unsigned ADDR_HI_BIT = 13;
  localparam int unsigned ADDR_LO_BIT = 12;
  localparam int unsigned SEL_HI_BIT  = 9;
  localparam int unsigned SEL_LO_BIT  = 8;
  localparam int unsigned NUM_CH      = 2;
endpackage

// File: rtl/svc_sync.sv
module svc_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/svc_shift.sv
module svc_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              slat_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(WORD_W);

  logic              sclk_d, slat_d;
  logic              sclk_rise, slat_rise;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign slat_rise = slat_i & ~slat_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b1;
      slat_d  <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d <= sclk_i;
      slat_d <= slat_i;
      if (sclk_rise) shreg_q <= {shreg_q[WORD_W-2:0], sdat_i};
      if (slat_rise)                          cnt_q <= '0;
      else if (sclk_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign commit_o = slat_rise && (cnt_q >= CNT_MIN);
  assign word_o   = shreg_q;

  // R1
  shift_msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> (shreg_q[0] == $past(sdat_i)) &&
                  (shreg_q[WORD_W-1:1] == $past(shreg_q[WORD_W-2:0])));
  // R3
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slat_rise |=> cnt_q == '0);
  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !slat_rise) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/svc_chan.sv
module svc_chan #(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned STEP_W   = 7,
  parameter int unsigned MAX_STEP = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [STEP_W-1:0] step_o,
  output logic              mute_o,
  output logic              upd_o
);
  localparam logic [CODE_W-1:0] CODE_LIM = CODE_W'(MAX_STEP);
  localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(MAX_STEP);

  logic [CODE_W-1:0] code_q;
  logic              upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '1;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= wr_i;
      if (wr_i) code_q <= code_i;
    end
  end

  // raw code kept; out-of-range codes read as mute
  assign mute_o = code_q > CODE_LIM;
  assign step_o = mute_o ? STEP_LIM : code_q[STEP_W-1:0];
  assign upd_o  = upd_q;

  // R9
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
  // R9
  quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(step_o) && $stable(mute_o));
  // R7
  mute_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> step_o == STEP_LIM);
  // R6
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o <= STEP_LIM);
endmodule

// File: rtl/serial_volume_ctrl.sv
module serial_volume_ctrl
  import svc_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned STEP_W      = 7,
  parameter int unsigned MAX_STEP    = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_lat_i,
  input  logic              strap_a1_i,
  input  logic              strap_a0_i,
  output logic [STEP_W-1:0] left_step_o,
  output logic              left_mute_o,
  output logic              left_upd_o,
  output logic [STEP_W-1:0] right_step_o,
  output logic              right_mute_o,
  output logic              right_upd_o
);
  logic [2:0]        ser_s;
  logic              commit;
  logic [WORD_W-1:0] word;
  logic              addr_ok;
  chan_sel_e         sel;
  logic [NUM_CH-1:0] wr;
  logic [NUM_CH-1:0] upd;
  logic [NUM_CH-1:0] mute;
  logic [STEP_W-1:0] step [NUM_CH];
  logic              unused_bits;

  svc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .q_o   (ser_s)
  );

  svc_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (ser_s[0]),
    .sdat_i  (ser_s[1]),
    .slat_i  (ser_s[2]),
    .commit_o(commit),
    .word_o  (word)
  );

  assign addr_ok = (word[ADDR_HI_BIT] == strap_a1_i) && (word[ADDR_LO_BIT] == strap_a0_i);
  assign sel     = chan_sel_e'(word[SEL_HI_BIT:SEL_LO_BIT]);
  assign wr[0]   = commit && addr_ok && (sel == SEL_BOTH || sel == SEL_LEFT);
  assign wr[1]   = commit && addr_ok && (sel == SEL_BOTH || sel == SEL_RIGHT);
  assign unused_bits = ^{word[WORD_W-1:ADDR_HI_BIT+1], word[ADDR_LO_BIT-1:SEL_HI_BIT+1]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    svc_chan #(.CODE_W(CODE_W), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr[ch]),
      .code_i(word[CODE_W-1:0]),
      .step_o(step[ch]),
      .mute_o(mute[ch]),
      .upd_o (upd[ch])
    );
  end

  assign left_step_o  = step[0];
  assign left_mute_o  = mute[0];
  assign left_upd_o   = upd[0];
  assign right_step_o = step[1];
  assign right_mute_o = mute[1];
  assign right_upd_o  = upd[1];

  // R4
  addr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_upd_o || right_upd_o) |-> $past(commit && addr_ok));
  // R5
  hold_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && sel == SEL_HOLD) |=> !left_upd_o && !right_upd_o);
  // R5
  left_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && addr_ok && sel == SEL_LEFT) |=> left_upd_o && !right_upd_o);
endmodule

// File: tb/serial_volume_ctrl_tb.sv
module serial_volume_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdat = 1'b0, slat = 1'b0;
  logic [6:0] l_step, r_step;
  logic       l_mute, r_mute, l_upd, r_upd;
  int         n_run = 0, n_fail = 0;
  int         l_cnt = 0, r_cnt = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  serial_volume_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_lat_i(slat),
    .strap_a1_i(1'b1), .strap_a0_i(1'b0),
    .left_step_o(l_step), .left_mute_o(l_mute), .left_upd_o(l_upd),
    .right_step_o(r_step), .right_mute_o(r_mute), .right_upd_o(r_upd)
  );

  always @(negedge clk) begin
    if (l_upd) l_cnt++;
    if (r_upd) r_cnt++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // shift nbits, the last 16 being w, then latch
  task automatic send(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = (i < 16) ? w[i] : ~w[i % 16];
      wait_cyc(4); sclk = 1'b1;
      wait_cyc(4); sclk = 1'b0;
    end
    wait_cyc(4); slat = 1'b1;
    wait_cyc(10); slat = 1'b0;
    wait_cyc(4);
  endtask

  function automatic logic [15:0] cmd(input logic [1:0] addr, input logic [1:0] sel,
                                      input logic [7:0] code);
    return {2'b00, addr, 2'b00, sel, code};
  endfunction

  task automatic expect_state(input string tag, input int ls, input int lm,
                              input int rs, input int rm);
    chk({tag, " left step"}, l_step, ls);
    chk({tag, " left mute"}, l_mute, lm);
    chk({tag, " right step"}, r_step, rs);
    chk({tag, " right mute"}, r_mute, rm);
  endtask

  task automatic expect_strobes(input string tag, input int l0, input int r0,
                                input int dl, input int dr);
    chk({tag, " left strobes"}, l_cnt - l0, dl);
    chk({tag, " right strobes"}, r_cnt - r0, dr);
  endtask

  task automatic t_reset;
    expect_state("R8 reset", 80, 1, 80, 1);
    chk("R8 no strobe", l_cnt + r_cnt, 0);
  endtask

  task automatic t_both;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b00, 8'h00), 16);
    expect_state("R5 R6 both 0dB", 0, 0, 0, 0);
    expect_strobes("R9 both", l0, r0, 1, 1);
  endtask

  task automatic t_left;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b01, 8'h50), 16);
    expect_state("R5 R6 left 80", 80, 0, 0, 0);
    expect_strobes("R5 left", l0, r0, 1, 0);
  endtask

  task automatic t_right;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b10, 8'h51), 16);
    expect_state("R7 right 0x51", 80, 0, 80, 1);
    expect_strobes("R5 right", l0, r0, 0, 1);
  endtask

  task automatic t_order;
    send(cmd(2'b10, 2'b10, 8'h2C), 16);
    expect_state("R1 msb first", 80, 0, 44, 0);
  endtask

  task automatic t_hold;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b11, 8'h10), 16);
    expect_state("R5 hold", 80, 0, 44, 0);
    expect_strobes("R5 hold", l0, r0, 0, 0);
  endtask

  task automatic t_addr_miss;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b01, 2'b00, 8'h05), 16);
    send(cmd(2'b11, 2'b00, 8'h05), 16);
    send(cmd(2'b00, 2'b00, 8'h05), 16);
    expect_state("R4 addr miss", 80, 0, 44, 0);
    expect_strobes("R4 addr miss", l0, r0, 0, 0);
  endtask

  task automatic t_short;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b00, 8'h07), 15);
    send(cmd(2'b10, 2'b00, 8'h08), 10);
    expect_state("R3 short burst", 80, 0, 44, 0);
    expect_strobes("R3 short burst", l0, r0, 0, 0);
  endtask

  task automatic t_long;
    send(cmd(2'b10, 2'b00, 8'h21), 40);
    expect_state("R2 long burst", 33, 0, 33, 0);
  endtask

  task automatic t_same;
    int l0 = l_cnt, r0 = r_cnt;
    send(cmd(2'b10, 2'b01, 8'h21), 16);
    expect_state("R9 same value", 33, 0, 33, 0);
    expect_strobes("R9 same value", l0, r0, 1, 0);
  endtask

  task automatic t_dontcare;
    send({2'b11, 2'b10, 2'b11, 2'b00, 8'hFF}, 16);
    expect_state("R10 R7 dont care 0xFF", 80, 1, 80, 1);
    send({2'b01, 2'b10, 2'b10, 2'b01, 8'h0A}, 16);
    expect_state("R10 dont care left", 10, 0, 80, 1);
  endtask

  task automatic t_rereset;
    int l0 = l_cnt, r0 = r_cnt;
    rst_n = 1'b0;
    wait_cyc(3);
    expect_state("R8 re-reset", 80, 1, 80, 1);
    rst_n = 1'b1;
    wait_cyc(6);
    expect_strobes("R8 re-reset", l0, r0, 0, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    t_reset();
    t_both();
    t_left();
    t_right();
    t_order();
    t_hold();
    t_addr_miss();
    t_short();
    t_long();
    t_same();
    t_dontcare();
    t_rereset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule